// File: doc/BRIEF.md
# Eight-Microphone Time-Multiplexed Serial Audio Capture

This block drives the shared bit clock and word-select clock of a linear array of eight serial-audio (I2S) digital microphones and collects their samples. A fast system clock is divided down to the bit clock, and the word-select clock runs at 1/64 of the bit-clock rate, so each word-select level lasts 32 bit-clock periods. Four serial data lines are shared by pairs of microphones. On every line one microphone answers while word-select is high and its partner answers while it is low, so eight channels arrive on four pins.

In each word-select half the first bit is a settling slot and is thrown away. The next 24 bits are a sample sent most significant bit first. The remaining bits of the half are ignored. Samples from the high half are held until the following low half has been captured. All eight words then change together with a one-cycle valid strobe, once per sample period. A downstream delay-and-sum beamformer reads the eight slots at each strobe.

Top module: `mic_array_capture`

## Requirements
- R1: While rst_ni is low, sck_o, ws_o and valid_o are 0 and samples_o is all zeros.
- R2: sck_o is periodic with a period of CLK_DIV system cycles and is high for CLK_DIV/2 of them (CLK_DIV even, default 40).
- R3: ws_o starts low after reset and changes level every 32 sck_o periods, always in the same system cycle as a falling edge of sck_o.
- R4: Serial data is sampled on the rising edge of sck_o. Counting sck_o periods from 0 after each ws_o change, period 0 is discarded and periods 1 to 24 give sample bits 23 down to 0.
- R5: Data in periods 25 to 31 of a half, and in period 0, has no effect on any output.
- R6: Line sd_i[l] carries microphone 2l+1 while ws_o is high and microphone 2l+2 while it is low. Microphone k (1..8) appears in samples_o[(k-1)*24 +: 24].
- R7: valid_o is a one-cycle pulse, high in the cycle after the system edge on which sck_o rises for period 24 of a low half. samples_o changes only in that cycle, with all eight slots updated together.
- R8: Each strobe carries the high half just before it and the low half ending at it. The low half that directly follows reset makes no strobe, so the first pulse follows system edge 88*CLK_DIV + CLK_DIV/2 after reset release.
- R9: After the first pulse, valid_o repeats every 64*CLK_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sd_i | input | NUM_LANES (4) | Shared serial data lines, one per microphone pair |
| sck_o | output | 1 | Bit clock to all microphones |
| ws_o | output | 1 | Word-select clock to all microphones |
| samples_o | output | 2*NUM_LANES*SAMPLE_W (192) | Eight sample slots, microphone 1 in the lowest 24 bits |
| valid_o | output | 1 | One-cycle strobe when a new set of eight samples is presented |

## Verification
The bench models each microphone as a shift register that answers on falling bit-clock edges. The first frames use directed words: all ones against all zeros, which exposes a window that is off by one bit, a single bit at a different position per microphone, which exposes swapped or misrouted slots, and a per-microphone tag. Later frames use seeded random words. During the discarded slots the line carries ones in the first frames and random bits later, so any leak of those slots into a sample changes a word. A reset in the middle of a frame checks the cleared outputs, the skipped first low half and the exact strobe timing that follows.

// File: rtl/mic_cap_pkg.sv
package mic_cap_pkg;
  localparam int unsigned BITS_PER_HALF = 32;  // 64 bit clocks per word-select period
  localparam int unsigned SKIP_BITS     = 1;   // settling slot after each word-select edge
endpackage

// File: rtl/mic_clk_gen.sv
module mic_clk_gen #(
  parameter  int unsigned CLK_DIV   = 40,
  parameter  int unsigned HALF_BITS = 32,
  localparam int unsigned CNT_W     = $clog2(CLK_DIV),
  localparam int unsigned IDX_W     = $clog2(HALF_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             sck_o,
  output logic             ws_o,
  output logic             rise_o,
  output logic [IDX_W-1:0] bit_idx_o
);
  localparam logic [CNT_W-1:0] RISE_AT  = CNT_W'(CLK_DIV/2 - 1);
  localparam logic [CNT_W-1:0] FALL_AT  = CNT_W'(CLK_DIV - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             sck_q, ws_q;
  logic             rise, fall;

  assign rise = (cnt_q == RISE_AT);
  assign fall = (cnt_q == FALL_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      sck_q <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      cnt_q <= fall ? '0 : cnt_q + 1'b1;
      if (rise) sck_q <= 1'b1;
      if (fall) begin
        sck_q <= 1'b0;
        // word-select moves only with a falling bit clock
        if (idx_q == LAST_IDX) begin
          idx_q <= '0;
          ws_q  <= ~ws_q;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign sck_o     = sck_q;
  assign ws_o      = ws_q;
  assign rise_o    = rise;
  assign bit_idx_o = idx_q;

  AST_WS_ON_SCK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_q != $past(ws_q)) |-> ($past(sck_q) && !sck_q)); // R3
  AST_RISE_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (!sck_o ##1 sck_o)); // R2
endmodule

// File: rtl/mic_lane_deser.sv
module mic_lane_deser #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sd_i,
  input  logic                shift_i,
  input  logic                hold_hi_i,
  output logic [SAMPLE_W-1:0] word_o,
  output logic [SAMPLE_W-1:0] hi_word_o
);
  logic [SAMPLE_W-1:0] sh_q, hi_q;

  // word including the bit on the line at this edge
  assign word_o = {sh_q[SAMPLE_W-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      hi_q <= '0;
    end else begin
      if (shift_i)   sh_q <= word_o;
      if (hold_hi_i) hi_q <= word_o;
    end
  end

  assign hi_word_o = hi_q;

  AST_HOLD_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_hi_i |-> shift_i); // R4
endmodule

// File: rtl/mic_array_capture.sv
module mic_array_capture #(
  parameter  int unsigned CLK_DIV   = 40,
  parameter  int unsigned SAMPLE_W  = 24,
  parameter  int unsigned NUM_LANES = 4,
  localparam int unsigned NUM_MICS  = 2 * NUM_LANES,
  localparam int unsigned OUT_W     = NUM_MICS * SAMPLE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] sd_i,
  output logic                 sck_o,
  output logic                 ws_o,
  output logic [OUT_W-1:0]     samples_o,
  output logic                 valid_o
);
  localparam int unsigned HALF_BITS = mic_cap_pkg::BITS_PER_HALF;
  localparam int unsigned IDX_W     = $clog2(HALF_BITS);
  localparam logic [IDX_W-1:0] FIRST_BIT = IDX_W'(mic_cap_pkg::SKIP_BITS);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(mic_cap_pkg::SKIP_BITS + SAMPLE_W - 1);

  logic             rise;
  logic [IDX_W-1:0] bit_idx;
  logic             in_win, last_bit, hi_done, frame_done;
  logic             primed_q, valid_q;
  logic [OUT_W-1:0] frame_d, samples_q;

  mic_clk_gen #(.CLK_DIV(CLK_DIV), .HALF_BITS(HALF_BITS)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_o    (sck_o),
    .ws_o     (ws_o),
    .rise_o   (rise),
    .bit_idx_o(bit_idx)
  );

  assign in_win     = rise && (bit_idx >= FIRST_BIT) && (bit_idx <= LAST_BIT);
  assign last_bit   = rise && (bit_idx == LAST_BIT);
  assign hi_done    = last_bit && ws_o;
  assign frame_done = last_bit && !ws_o && primed_q;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [SAMPLE_W-1:0] word, hi_word;
    mic_lane_deser #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sd_i     (sd_i[l]),
      .shift_i  (in_win),
      .hold_hi_i(hi_done),
      .word_o   (word),
      .hi_word_o(hi_word)
    );
    // odd microphone on the high half, even on the low half
    assign frame_d[(2*l)*SAMPLE_W   +: SAMPLE_W] = hi_word;
    assign frame_d[(2*l+1)*SAMPLE_W +: SAMPLE_W] = word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q  <= 1'b0;
      valid_q   <= 1'b0;
      samples_q <= '0;
    end else begin
      if (hi_done) primed_q <= 1'b1;
      valid_q <= frame_done;
      if (frame_done) samples_q <= frame_d;
    end
  end

  assign samples_o = samples_q;
  assign valid_o   = valid_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
  AST_VALID_IN_LOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !ws_o); // R8
  AST_VALID_AT_SCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(sck_o)); // R7
  AST_SAMPLES_ONLY_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(samples_o) |-> valid_o); // R7
endmodule

// File: tb/sim_mic_array_capture.sv
module sim_mic_array_capture;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 40;
  localparam int W          = 24;
  localparam int LANES      = 4;
  localparam int MICS       = 2 * LANES;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LANES-1:0] sd = '0;
  logic             sck, ws, valid;
  logic [MICS*W-1:0] samples;

  mic_array_capture #(.CLK_DIV(CLK_DIV), .SAMPLE_W(W), .NUM_LANES(LANES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sd_i(sd), .sck_o(sck), .ws_o(ws),
    .samples_o(samples), .valid_o(valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;
  logic [W-1:0] mic_word [MICS];
  int hf = 0;        // high halves seen, selects directed patterns
  int nvalid = 0;    // strobes since last reset
  bit mon_en = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] gen_word(input int frame, input int mic);
    case (frame)
      1: return (mic % 2 == 0) ? 24'hFFFFFF : 24'h000000;
      2: return 24'h000001 << (mic * 3);
      3: return 24'hA5A500 | 24'(mic + 1);
      default: return 24'($urandom);
    endcase
  endfunction

  // microphone models: answer on falling sck
  initial begin
    int pos;
    logic ws_prev;
    pos = 0; ws_prev = 1'b0;
    for (int m = 0; m < MICS; m++) mic_word[m] = '0;
    forever begin
      @(negedge sck or negedge rst_n);
      #1;
      if (!rst_n) begin
        pos = 0; ws_prev = 1'b0; sd = '0;
        continue;
      end
      if (ws != ws_prev) begin
        pos = 0;
        ws_prev = ws;
        if (ws) hf++;
        for (int l = 0; l < LANES; l++)
          mic_word[ws ? 2*l : 2*l+1] = gen_word(hf, ws ? 2*l : 2*l+1);
      end else begin
        pos++;
      end
      for (int l = 0; l < LANES; l++) begin
        int m;
        m = ws ? 2*l : 2*l+1;
        if (pos >= 1 && pos <= W) sd[l] = mic_word[m][W-pos];
        else sd[l] = (hf < 4) ? 1'b1 : 1'($urandom); // R5 junk in discarded slots
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc = rst_n ? cyc + 1 : 0;

  // timing and data monitor, sampled mid-cycle
  initial begin
    logic sck_p, ws_p, valid_p;
    int last_rise, last_ws, last_valid, nper, nhigh, nws;
    logic [MICS*W-1:0] last_frame;
    sck_p = 0; ws_p = 0; valid_p = 0;
    last_rise = -1; last_ws = 0; last_valid = -1; nper = 0; nhigh = 0; nws = 0;
    last_frame = '0;
    forever begin
      @(negedge clk);
      if (!rst_n || !mon_en) begin
        sck_p = 0; ws_p = 0; valid_p = 0;
        last_rise = -1; last_ws = 0; last_valid = -1; nper = 0; nhigh = 0; nws = 0;
        last_frame = '0; nvalid = 0;
        continue;
      end
      if (sck && !sck_p) begin
        if (last_rise >= 0 && nper < 6) begin
          nper++;
          chk(cyc - last_rise == CLK_DIV, "R2", "sck period", 64'(cyc - last_rise), 64'(CLK_DIV));
        end
        last_rise = cyc;
      end
      if (!sck && sck_p && nhigh < 6) begin
        nhigh++;
        chk(cyc - last_rise == CLK_DIV/2, "R2", "sck high time", 64'(cyc - last_rise), 64'(CLK_DIV/2));
      end
      if (ws != ws_p) begin
        chk(sck_p && !sck, "R3", "ws edge not at sck fall", 64'({sck_p, sck}), 64'h2);
        if (nws < 6) chk(cyc - last_ws == 32*CLK_DIV, "R3", "ws half length",
                         64'(cyc - last_ws), 64'(32*CLK_DIV));
        nws++;
        last_ws = cyc;
      end
      if (valid_p) chk(!valid, "R7", "valid width", 64'(valid), 64'h0);
      if (valid) begin
        if (nvalid == 0)
          chk(cyc == 88*CLK_DIV + CLK_DIV/2, "R8", "first strobe edge", 64'(cyc),
              64'(88*CLK_DIV + CLK_DIV/2));
        else
          chk(cyc - last_valid == 64*CLK_DIV, "R9", "strobe interval",
              64'(cyc - last_valid), 64'(64*CLK_DIV));
        chk(!ws, "R8", "strobe in low half", 64'(ws), 64'h0);
        for (int m = 0; m < MICS; m++)
          chk(samples[m*W +: W] == mic_word[m], (m % 2 == 0) ? "R6 high-half slot" : "R6 low-half slot",
              $sformatf("R4 mic%0d", m + 1), 64'(samples[m*W +: W]), 64'(mic_word[m]));
        last_frame = samples;
        last_valid = cyc;
        nvalid++;
      end else if (nvalid > 0 && (cyc - last_valid) % 512 == 0) begin
        chk(samples == last_frame, "R7", "samples held between strobes",
            64'(samples[W-1:0]), 64'(last_frame[W-1:0]));
      end
      sck_p = sck; ws_p = ws; valid_p = valid;
    end
  end

  task automatic check_reset_state();
    chk(sck == 1'b0, "R1", "sck in reset", 64'(sck), 64'h0);
    chk(ws == 1'b0, "R1", "ws in reset", 64'(ws), 64'h0);
    chk(valid == 1'b0, "R1", "valid in reset", 64'(valid), 64'h0);
    chk(samples == '0, "R1", "samples in reset", 64'(samples[63:0]), 64'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    int unsigned seed_r;
    seed_r = $urandom(32'd20241);
    repeat (5) @(negedge clk);
    check_reset_state();
    mon_en = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    wait (nvalid == 10);
    repeat (1234) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();   // R1 after mid-frame reset
    rst_n = 1'b1;
    wait (nvalid == 6);
    repeat (20) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d strobes", nvalid, 6);
    finish_run();
  end
endmodule